// File: doc/BRIEF.md
# DMA Enable and Request Controller

This block sits between the programming registers of a bus-master DMA channel and the bus interface state machine. It decides when the channel may ask for the bus, which transfer direction (read or write) gets each bus tenure, and which interrupt line reports completion or failure. A mode input selects who owns the channel. In host-owned mode, a pair of sticky enable bits written by the host controls the two directions. In add-on-owned mode, two local enable pins control them instead. The mode also decides which side is allowed to write the channel's address and count registers.

Each direction asks for the bus only when it is enabled, its FIFO condition holds, and it is not blocked by an earlier abort. When both directions qualify, they take turns. After a grant, the block issues a one-cycle start pulse for the chosen direction. It keeps the bus request asserted until the bus interface reports that the transaction is done, even if the enable is removed partway through.

Count-zero and abort events set sticky status bits, which are cleared by writing one. Any set bit raises the interrupt of the side that owns the channel.

Top module: `dma_req_ctrl`

## Requirements
- R1: `host_cfg_wr_ok` equals `host_cfg_wr_req` when `mode_addon`=0 and is 0 otherwise. `local_cfg_wr_ok` equals `local_cfg_wr_req` when `mode_addon`=1 and is 0 otherwise. The two are never high together.
- R2: In host mode, a direction d (index 0 = read, 1 = write) qualifies when its host enable bit d is set, `fifo_ok[d]` is 1, and its abort status bit is clear. `bus_req` rises when at least one direction qualifies, and each direction is enabled independently of the other.
- R3: Host enable bits are written as a pair by `host_ctl_we` and keep their value until the next such write. A count-zero event or a completed transaction does not clear them.
- R4: In add-on mode, the host enable bits have no effect, and `ao_en[d]` takes their place in the rule of R2.
- R5: Once a transaction has started, `bus_req` stays high until the clock edge at which `xact_done` is sampled high, even if the enable of that direction falls. With no qualifying direction left, `bus_req` is low after that edge.
- R6: `sts` holds four sticky bits. Bit 2d is set by `tc_hit[d]`, and bit 2d+1 is set by `tgt_abort[d]` or `mst_abort[d]`. A bit clears only when `sts_clr_we` is high with a 1 in that bit of `sts_clr`, and bits written with 0 are left unchanged.
- R7: When any `sts` bit is set, `host_irq` is high in host mode and `local_irq` is high in add-on mode. Both are low when `sts` is zero.
- R8: When both directions qualify at arbitration time, the direction other than the one granted last wins. After reset, read is preferred.
- R9: While the abort bit of direction d is set, d never qualifies. After that bit is cleared, requests for d resume.
- R10: A grant (`bus_gnt` high while `bus_req` is high, and the chosen direction still qualifies) produces a one-cycle pulse on `start`, one-hot with bit 0 = read and bit 1 = write, in the cycle after the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_addon | input | 1 | 0 = host owns the channel, 1 = add-on side owns it |
| host_cfg_wr_req | input | 1 | Host attempts an address/count register write |
| local_cfg_wr_req | input | 1 | Local side attempts an address/count register write |
| host_cfg_wr_ok | output | 1 | Host write permitted |
| local_cfg_wr_ok | output | 1 | Local write permitted |
| host_ctl_we | input | 1 | Write strobe for the host enable pair |
| host_ctl_en | input | 2 | New host enable values (bit 0 read, bit 1 write) |
| ao_en | input | 2 | Add-on enable pins (bit 0 read, bit 1 write) |
| fifo_ok | input | 2 | FIFO condition satisfied per direction |
| tc_hit | input | 2 | Transfer count reached zero, per direction |
| tgt_abort | input | 2 | Target abort seen, per direction |
| mst_abort | input | 2 | Master abort seen, per direction |
| xact_done | input | 1 | Current bus transaction has ended |
| bus_gnt | input | 1 | Bus granted to this channel |
| bus_req | output | 1 | Bus request |
| start | output | 2 | One-cycle start pulse per direction |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 4 | Write-one-to-clear mask for `sts` |
| sts | output | 4 | Sticky status: {wr abort, wr count zero, rd abort, rd count zero} |
| host_irq | output | 1 | Interrupt to host |
| local_irq | output | 1 | Interrupt to local side |

## Verification
The bench sweeps every combination of mode, host enable pair, add-on pins and FIFO conditions. It predicts the request and the granted direction with a model of the alternating priority. A design that mixed up the two enable sources, or let one direction's enable act on the other, would raise a request or start the wrong direction here.

Separate sequences cover the remaining rules. An enable is dropped during a live transaction: a design that released the bus early would show `bus_req` falling before `xact_done`. A count-zero event is followed by a new request, which exposes host enables that clear themselves. Each abort kind is applied to each direction, which exposes a design that keeps requesting or never recovers after the clear. Every status bit is set and then cleared with both matching and non-matching masks in both modes, which exposes wrong bit positions and misrouted interrupts.

// File: rtl/dmarc_pkg.sv
package dmarc_pkg;

    localparam int NDIR   = 2;
    localparam int DIR_RD = 0;
    localparam int DIR_WR = 1;
    localparam int STS_W  = 2 * NDIR;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_REQ  = 2'd1,
        ARB_BUSY = 2'd2
    } arb_state_e;

    // per-direction sticky status, packed as {abort, count-zero}
    typedef struct packed {
        logic abt;
        logic tc;
    } dir_sts_t;

    function automatic logic [NDIR-1:0] dir_onehot(input logic d);
        logic [NDIR-1:0] v;
        v = '0;
        v[d] = 1'b1;
        return v;
    endfunction

    // choose the winner: alternate when both qualify, else the single one
    function automatic logic pick_dir(input logic [NDIR-1:0] want, input logic last);
        if (want[DIR_RD] && want[DIR_WR])
            return ~last;
        return want[DIR_WR];
    endfunction

endpackage

// File: rtl/dmarc_enable_sel.sv
module dmarc_enable_sel
    import dmarc_pkg::*;
(
    input  logic            mode_addon,
    input  logic [NDIR-1:0] host_en,
    input  logic [NDIR-1:0] ao_en,
    input  logic [NDIR-1:0] fifo_ok,
    input  logic [NDIR-1:0] blocked,
    output logic [NDIR-1:0] want
);

    logic [NDIR-1:0] eff_en;

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            always_comb begin
                eff_en[d] = mode_addon ? ao_en[d] : host_en[d];
                want[d]   = eff_en[d] & fifo_ok[d] & ~blocked[d];
            end
        end
    endgenerate

endmodule

// File: rtl/dmarc_dir_status.sv
module dmarc_dir_status
    import dmarc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tc_evt,
    input  logic     abt_evt,
    input  logic     clr_tc,
    input  logic     clr_abt,
    output dir_sts_t sts_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            sts_q.tc  <= tc_evt  | (sts_q.tc  & ~clr_tc);
            sts_q.abt <= abt_evt | (sts_q.abt & ~clr_abt);
        end
    end

endmodule

// File: rtl/dmarc_arbiter.sv
module dmarc_arbiter
    import dmarc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NDIR-1:0] want,
    input  logic            bus_gnt,
    input  logic            xact_done,
    output logic            bus_req,
    output logic [NDIR-1:0] start
);

    arb_state_e state_q;
    logic       cur_q;
    logic       last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            cur_q   <= 1'b0;
            last_q  <= 1'b1;
            start   <= '0;
        end else begin
            start <= '0;
            unique case (state_q)
                ARB_IDLE: begin
                    if (|want) begin
                        cur_q   <= pick_dir(want, last_q);
                        state_q <= ARB_REQ;
                    end
                end
                ARB_REQ: begin
                    if (!want[cur_q]) begin
                        state_q <= ARB_IDLE;
                    end else if (bus_gnt) begin
                        start   <= dir_onehot(cur_q);
                        last_q  <= cur_q;
                        state_q <= ARB_BUSY;
                    end
                end
                ARB_BUSY: begin
                    if (xact_done)
                        state_q <= ARB_IDLE;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign bus_req = (state_q != ARB_IDLE);

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dmarc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_addon,
    input  logic             host_cfg_wr_req,
    input  logic             local_cfg_wr_req,
    output logic             host_cfg_wr_ok,
    output logic             local_cfg_wr_ok,
    input  logic             host_ctl_we,
    input  logic [NDIR-1:0]  host_ctl_en,
    input  logic [NDIR-1:0]  ao_en,
    input  logic [NDIR-1:0]  fifo_ok,
    input  logic [NDIR-1:0]  tc_hit,
    input  logic [NDIR-1:0]  tgt_abort,
    input  logic [NDIR-1:0]  mst_abort,
    input  logic             xact_done,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic [NDIR-1:0]  start,
    input  logic             sts_clr_we,
    input  logic [STS_W-1:0] sts_clr,
    output logic [STS_W-1:0] sts,
    output logic             host_irq,
    output logic             local_irq
);

    logic [NDIR-1:0] host_en_q;
    logic [NDIR-1:0] blocked;
    logic [NDIR-1:0] want;
    dir_sts_t        dsts [NDIR];

    // host enable pair: changes only on an explicit write
    always_ff @(posedge clk) begin
        if (rst)
            host_en_q <= '0;
        else if (host_ctl_we)
            host_en_q <= host_ctl_en;
    end

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_sts
            dmarc_dir_status u_sts (
                .clk     (clk),
                .rst     (rst),
                .tc_evt  (tc_hit[d]),
                .abt_evt (tgt_abort[d] | mst_abort[d]),
                .clr_tc  (sts_clr_we & sts_clr[2*d]),
                .clr_abt (sts_clr_we & sts_clr[2*d+1]),
                .sts_q   (dsts[d])
            );
            assign sts[2*d]   = dsts[d].tc;
            assign sts[2*d+1] = dsts[d].abt;
            assign blocked[d] = dsts[d].abt;
        end
    endgenerate

    dmarc_enable_sel u_en (
        .mode_addon (mode_addon),
        .host_en    (host_en_q),
        .ao_en      (ao_en),
        .fifo_ok    (fifo_ok),
        .blocked    (blocked),
        .want       (want)
    );

    dmarc_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .bus_gnt   (bus_gnt),
        .xact_done (xact_done),
        .bus_req   (bus_req),
        .start     (start)
    );

    always_comb begin
        host_cfg_wr_ok  = host_cfg_wr_req  & ~mode_addon;
        local_cfg_wr_ok = local_cfg_wr_req &  mode_addon;
        host_irq        = (|sts) & ~mode_addon;
        local_irq       = (|sts) &  mode_addon;
    end

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk
    import dmarc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode_addon,
    input logic             host_cfg_wr_ok,
    input logic             local_cfg_wr_ok,
    input logic             xact_done,
    input logic             bus_gnt,
    input logic             bus_req,
    input logic [NDIR-1:0]  start,
    input logic             sts_clr_we,
    input logic [STS_W-1:0] sts_clr,
    input logic [STS_W-1:0] sts,
    input logic             host_irq,
    input logic             local_irq
);

    logic busy_c;

    always_ff @(posedge clk) begin
        if (rst)
            busy_c <= 1'b0;
        else
            busy_c <= (busy_c | (|start)) & ~xact_done;
    end

    AST_CFG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(host_cfg_wr_ok && local_cfg_wr_ok)); // R1
    AST_CFG_HOST_MODE: assert property (@(posedge clk) disable iff (rst)
        host_cfg_wr_ok |-> !mode_addon); // R1
    AST_HOLD_TILL_DONE: assert property (@(posedge clk) disable iff (rst)
        busy_c |-> bus_req); // R5
    AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (rst)
        !(host_irq && local_irq) && ((host_irq || local_irq) == (|sts))); // R7
    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start)); // R10
    AST_START_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        (|start) |-> ($past(bus_gnt) && $past(bus_req))); // R10
    AST_RD_ABT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        start[DIR_RD] |-> !$past(sts[2*DIR_RD+1])); // R9
    AST_WR_ABT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        start[DIR_WR] |-> !$past(sts[2*DIR_WR+1])); // R9

    generate
        for (genvar i = 0; i < STS_W; i++) begin : g_sticky
            AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
                ($past(sts[i]) && !($past(sts_clr_we) && $past(sts_clr[i]))) |-> sts[i]); // R6
        end
    endgenerate

endmodule

bind dma_req_ctrl dma_req_ctrl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .mode_addon      (mode_addon),
    .host_cfg_wr_ok  (host_cfg_wr_ok),
    .local_cfg_wr_ok (local_cfg_wr_ok),
    .xact_done       (xact_done),
    .bus_gnt         (bus_gnt),
    .bus_req         (bus_req),
    .start           (start),
    .sts_clr_we      (sts_clr_we),
    .sts_clr         (sts_clr),
    .sts             (sts),
    .host_irq        (host_irq),
    .local_irq       (local_irq)
);

// File: tb/dma_req_ctrl_tb_top.sv
module dma_req_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_addon = 1'b0;
    logic       host_cfg_wr_req = 1'b0, local_cfg_wr_req = 1'b0;
    logic       host_cfg_wr_ok, local_cfg_wr_ok;
    logic       host_ctl_we = 1'b0;
    logic [1:0] host_ctl_en = '0, ao_en = '0, fifo_ok = '0;
    logic [1:0] tc_hit = '0, tgt_abort = '0, mst_abort = '0;
    logic       xact_done = 1'b0, bus_gnt = 1'b0;
    logic       bus_req;
    logic [1:0] start;
    logic       sts_clr_we = 1'b0;
    logic [3:0] sts_clr = '0;
    logic [3:0] sts;
    logic       host_irq, local_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic last_dir = 1'b1;

    always #4 clk = ~clk;

    dma_req_ctrl dut_i (
        .clk(clk), .rst(rst), .mode_addon(mode_addon),
        .host_cfg_wr_req(host_cfg_wr_req), .local_cfg_wr_req(local_cfg_wr_req),
        .host_cfg_wr_ok(host_cfg_wr_ok), .local_cfg_wr_ok(local_cfg_wr_ok),
        .host_ctl_we(host_ctl_we), .host_ctl_en(host_ctl_en), .ao_en(ao_en),
        .fifo_ok(fifo_ok), .tc_hit(tc_hit), .tgt_abort(tgt_abort),
        .mst_abort(mst_abort), .xact_done(xact_done), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .start(start), .sts_clr_we(sts_clr_we),
        .sts_clr(sts_clr), .sts(sts), .host_irq(host_irq), .local_irq(local_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] en);
        host_ctl_en = en;
        host_ctl_we = 1'b1;
        tick(1);
        host_ctl_we = 1'b0;
    endtask

    // grant, check start, finish transaction with optional events
    task automatic run_xact(input string req, input logic exp_dir,
                            input logic [1:0] tc, input logic [1:0] ta, input logic [1:0] ma);
        bus_gnt = 1'b1;
        tick(1);
        bus_gnt = 1'b0;
        chk(req, {30'd0, start}, {30'd0, (exp_dir ? 2'b10 : 2'b01)});
        last_dir = exp_dir;
        xact_done = 1'b1; tc_hit = tc; tgt_abort = ta; mst_abort = ma;
        tick(1);
        xact_done = 1'b0; tc_hit = '0; tgt_abort = '0; mst_abort = '0;
    endtask

    task automatic clear_sts(input logic [3:0] m);
        sts_clr = m;
        sts_clr_we = 1'b1;
        tick(1);
        sts_clr_we = 1'b0;
        sts_clr = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] elig;
        logic       exp_dir;
        tick(3);
        rst = 1'b0;
        tick(1);
        // reset state
        chk("R10 reset start", {30'd0, start}, 32'd0);
        chk("R5 reset bus_req", {31'd0, bus_req}, 32'd0);
        chk("R6 reset sts", {28'd0, sts}, 32'd0);

        // R1: access permission for every mode/request combination
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 4; r++) begin
                mode_addon = m[0];
                host_cfg_wr_req = r[0];
                local_cfg_wr_req = r[1];
                #1;
                chk("R1 host ok", {31'd0, host_cfg_wr_ok}, {31'd0, r[0] & ~m[0]});
                chk("R1 local ok", {31'd0, local_cfg_wr_ok}, {31'd0, r[1] & m[0]});
            end
        end
        host_cfg_wr_req = 1'b0; local_cfg_wr_req = 1'b0; mode_addon = 1'b0;
        tick(1);

        // R2 R4 R8: sweep mode x host pair x pins x fifo
        for (int m = 0; m < 2; m++) begin
            for (int h = 0; h < 4; h++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int f = 0; f < 4; f++) begin
                        mode_addon = m[0];
                        ao_en = a[1:0];
                        fifo_ok = f[1:0];
                        host_write(h[1:0]);
                        tick(1);
                        elig = (m[0] ? a[1:0] : h[1:0]) & f[1:0];
                        chk(m[0] ? "R4 req" : "R2 req", {31'd0, bus_req}, {31'd0, |elig});
                        if (|elig) begin
                            exp_dir = (elig == 2'b11) ? ~last_dir : elig[1];
                            run_xact((elig == 2'b11) ? "R8 dir" : "R10 dir", exp_dir, '0, '0, '0);
                        end
                        ao_en = '0; fifo_ok = '0;
                        host_write(2'b00);
                    end
                end
            end
        end
        tick(2);

        // R8: back-to-back alternation with both directions ready
        mode_addon = 1'b0;
        fifo_ok = 2'b11;
        host_write(2'b11);
        for (int k = 0; k < 4; k++) begin
            tick(1);
            chk("R8 req", {31'd0, bus_req}, 32'd1);
            run_xact("R8 alternate", ~last_dir, '0, '0, '0);
        end
        fifo_ok = '0;
        host_write(2'b00);
        tick(2);

        // R3: count-zero does not clear the host enable
        fifo_ok = 2'b01;
        host_write(2'b01);
        tick(1);
        run_xact("R3 first", 1'b0, 2'b01, '0, '0);
        chk("R3 tc status", {28'd0, sts}, 32'h1);
        tick(1);
        chk("R3 enable kept", {31'd0, bus_req}, 32'd1);
        run_xact("R3 second", 1'b0, '0, '0, '0);
        fifo_ok = '0;
        host_write(2'b00);
        clear_sts(4'hF);
        tick(2);

        // R5: add-on enable drops mid-transaction
        mode_addon = 1'b1;
        ao_en = 2'b10; fifo_ok = 2'b10;
        tick(1);
        bus_gnt = 1'b1;
        tick(1);
        bus_gnt = 1'b0;
        chk("R5 start wr", {30'd0, start}, 32'h2);
        last_dir = 1'b1;
        ao_en = '0;
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk("R5 held", {31'd0, bus_req}, 32'd1);
        end
        xact_done = 1'b1;
        tick(1);
        xact_done = 1'b0;
        chk("R5 released", {31'd0, bus_req}, 32'd0);
        tick(1);
        chk("R5 stays low", {31'd0, bus_req}, 32'd0);
        fifo_ok = '0;
        mode_addon = 1'b0;
        tick(1);

        // R9: each abort kind on each direction blocks until cleared
        for (int d = 0; d < 2; d++) begin
            for (int kind = 0; kind < 2; kind++) begin
                fifo_ok = d[0] ? 2'b10 : 2'b01;
                host_write(d[0] ? 2'b10 : 2'b01);
                tick(1);
                run_xact("R9 start", d[0], '0,
                         kind == 0 ? fifo_ok : 2'b00, kind == 1 ? fifo_ok : 2'b00);
                tick(3);
                chk("R9 blocked", {31'd0, bus_req}, 32'd0);
                chk("R9 abort bit", {28'd0, sts}, 32'd1 << (2*d+1));
                chk("R7 host irq", {31'd0, host_irq}, 32'd1);
                clear_sts(4'd1 << (2*d+1));
                tick(1);
                chk("R9 resumed", {31'd0, bus_req}, 32'd1);
                run_xact("R9 restart", d[0], '0, '0, '0);
                fifo_ok = '0;
                host_write(2'b00);
                tick(1);
            end
        end

        // R6 R7: each status bit, both modes, wrong then right clear mask
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 4; b++) begin
                mode_addon = m[0];
                if (b % 2 == 0) tc_hit[b/2] = 1'b1;
                else if (m == 0) tgt_abort[b/2] = 1'b1;
                else mst_abort[b/2] = 1'b1;
                tick(1);
                tc_hit = '0; tgt_abort = '0; mst_abort = '0;
                tick(1);
                chk("R6 set", {28'd0, sts}, 32'd1 << b);
                chk("R7 host irq", {31'd0, host_irq}, {31'd0, ~m[0]});
                chk("R7 local irq", {31'd0, local_irq}, {31'd0, m[0]});
                clear_sts(~(4'd1 << b));
                chk("R6 kept", {28'd0, sts}, 32'd1 << b);
                clear_sts(4'd1 << b);
                chk("R6 cleared", {28'd0, sts}, 32'd0);
                chk("R7 irq low", {30'd0, host_irq, local_irq}, 32'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule